// File: doc/BRIEF.md
# Hardware Return Stack Pointer

This block is a small last-in-first-out store of sixteen 16-bit words kept on chip. A 4-bit pointer selects the slot. A push strobe writes the supplied word into the slot the pointer names and then moves the pointer up by one. A pop strobe moves the pointer down by one and then returns the word held in the slot it now names. The pointer arithmetic wraps at sixteen.

The pointer can also be read and written as a 16-bit register. Only its low four bits carry state. The upper bits read back as zero, and a write ignores them.

Two diagnostic pulses report a push into a full stack and a pop from an empty one. An internal fill count, from 0 to 16, tracks fullness. These pulses never block pointer movement. The storage array is not cleared by reset.

Top module: `rstk_top`

## Requirements
- R1: After reset the register view reads 000Fh, `popData` reads 0000h, and both `overflow` and `underflow` are low.
- R2: A push (`pushEn` high, `spWrEn` low) writes `pushData` into the slot at the current pointer. The pointer read back one clock later is the old value plus one.
- R3: A pop (`popEn` high, `pushEn` and `spWrEn` low) lowers the pointer by one. One clock later, `popData` holds the word stored in the slot at the lowered pointer.
- R4: Pointer arithmetic is modulo 16: a push at Fh leaves 0h, and a pop at 0h leaves Fh.
- R5: Bits 15:4 of `spRdData` are always zero, and bits 3:0 hold the pointer.
- R6: A register write (`spWrEn` high) loads `spWrData[3:0]` into the pointer and ignores `spWrData[15:4]`. It takes priority over push and pop in the same cycle, so neither the pointer step nor the store happens.
- R7: When `pushEn` and `popEn` are both high without a register write, the block performs a push only, and `popData` is unchanged.
- R8: A push issued while 16 entries are held raises `overflow` for one clock on the next cycle. The store and the pointer step still happen, and the count stays at 16.
- R9: A pop issued while no entries are held raises `underflow` for one clock on the next cycle. The pointer still steps down.
- R10: The fill count goes up on each push (saturating at 16) and down on each pop (saturating at 0). A register write leaves it unchanged.
- R11: Without a pop, `popData` keeps its value. Without any strobe, the pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushEn | input | 1 | Push strobe |
| popEn | input | 1 | Pop strobe |
| pushData | input | 16 | Word to push |
| spWrEn | input | 1 | Pointer register write strobe |
| spWrData | input | 16 | Pointer register write value (bits 3:0 used) |
| popData | output | 16 | Word returned by the last pop |
| spRdData | output | 16 | Pointer register view |
| overflow | output | 1 | Push-into-full pulse |
| underflow | output | 1 | Pop-from-empty pulse |

## Verification
Some properties hold on every cycle, and the assertions check those continuously:
- the pointer step for each strobe kind;
- register-write loading and its priority;
- the zero upper bits;
- the two flags never being high together;
- the hold of `popData` and of the pointer when no strobe is given.

Other behaviour depends on storage contents or on the hidden fill count, so only the bench's scenarios can show it:
- that a pop returns the word pushed into that slot;
- that push-with-pop stores data;
- that a register write blocks the store;
- when the flags fire after a full fill and a full drain.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  localparam int unsigned STK_AW    = 4;
  localparam int unsigned STK_DEPTH = 1 << STK_AW;

  typedef logic [STK_AW-1:0] stkPtr_t;

  // strobes handed from control to datapath
  typedef struct packed {
    logic    wrEn;
    stkPtr_t wrAddr;
    logic    rdEn;
    stkPtr_t rdAddr;
  } stkStrobe_t;
endpackage

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pushReq,
  input  logic       popReq,
  input  logic       ptrLoad,
  input  stkPtr_t    ptrLoadVal,
  output stkStrobe_t strb,
  output stkPtr_t    ptr,
  output logic       ovfPulse,
  output logic       undPulse
);
  localparam int unsigned CNT_W = STK_AW + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(STK_DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam stkPtr_t RESET_PTR = '1;
  localparam stkPtr_t PTR_ONE = stkPtr_t'(1);

  logic doPush, doPop, isFull, isEmpty;
  stkPtr_t ptrInc, ptrDec, ptrNext;
  logic [CNT_W-1:0] fill, fillNext;

  // priority: register write, then push, then pop
  always_comb begin
    doPush  = pushReq & ~ptrLoad;
    doPop   = popReq & ~pushReq & ~ptrLoad;
    isFull  = (fill == FULL_CNT);
    isEmpty = (fill == '0);
    ptrInc  = ptr + PTR_ONE;
    ptrDec  = ptr - PTR_ONE;
  end

  always_comb begin
    ptrNext  = ptr;
    fillNext = fill;
    if (ptrLoad) begin
      ptrNext = ptrLoadVal;
    end else if (doPush) begin
      ptrNext = ptrInc;
      if (!isFull) fillNext = fill + CNT_ONE;
    end else if (doPop) begin
      ptrNext = ptrDec;
      if (!isEmpty) fillNext = fill - CNT_ONE;
    end
  end

  // store at old pointer; read at decremented pointer
  always_comb begin
    strb.wrEn   = doPush;
    strb.wrAddr = ptr;
    strb.rdEn   = doPop;
    strb.rdAddr = ptrDec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= RESET_PTR;
      fill     <= '0;
      ovfPulse <= 1'b0;
      undPulse <= 1'b0;
    end else begin
      ptr      <= ptrNext;
      fill     <= fillNext;
      ovfPulse <= doPush & isFull;
      undPulse <= doPop & isEmpty;
    end
  end
endmodule

// File: rtl/rstk_dpath.sv
module rstk_dpath
  import rstk_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  // storage array: not reset
  logic [DATA_W-1:0] mem [STK_DEPTH];

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[strb.wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      rdData <= mem[strb.rdAddr];
    end
  end
endmodule

// File: rtl/rstk_top.sv
module rstk_top
  import rstk_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic              popEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              spWrEn,
  input  logic [REG_W-1:0]  spWrData,
  output logic [DATA_W-1:0] popData,
  output logic [REG_W-1:0]  spRdData,
  output logic              overflow,
  output logic              underflow
);
  stkStrobe_t strb;
  stkPtr_t    ptr;

  rstk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pushReq    (pushEn),
    .popReq     (popEn),
    .ptrLoad    (spWrEn),
    .ptrLoadVal (spWrData[STK_AW-1:0]),
    .strb       (strb),
    .ptr        (ptr),
    .ovfPulse   (overflow),
    .undPulse   (underflow)
  );

  rstk_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (pushData),
    .rdData (popData)
  );

  // reserved upper bits read as zero
  generate
    if (REG_W > STK_AW) begin : g_pad
      assign spRdData = {{(REG_W-STK_AW){1'b0}}, ptr};
    end else begin : g_nopad
      assign spRdData = ptr[REG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rstk_check.sv
module rstk_check
  import rstk_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned REG_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushEn,
  input logic              popEn,
  input logic              spWrEn,
  input logic [REG_W-1:0]  spWrData,
  input logic [DATA_W-1:0] popData,
  input logic [REG_W-1:0]  spRdData,
  input logic              overflow,
  input logic              underflow
);
  localparam stkPtr_t ONE = stkPtr_t'(1);

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    spRdData[REG_W-1:STK_AW] == '0);

  a_r2_push_advance: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !spWrEn) |=> spRdData[STK_AW-1:0] == stkPtr_t'($past(spRdData[STK_AW-1:0]) + ONE));

  a_r3_pop_retreat: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && !spWrEn) |=> spRdData[STK_AW-1:0] == stkPtr_t'($past(spRdData[STK_AW-1:0]) - ONE));

  a_r6_write_load: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |=> spRdData[STK_AW-1:0] == $past(spWrData[STK_AW-1:0]));

  a_r11_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!pushEn && !popEn && !spWrEn) |=> $stable(spRdData));

  a_r11_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(popEn && !pushEn && !spWrEn) |=> $stable(popData));

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({overflow, underflow}));
endmodule

bind rstk_top rstk_check #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pushEn    (pushEn),
  .popEn     (popEn),
  .spWrEn    (spWrEn),
  .spWrData  (spWrData),
  .popData   (popData),
  .spRdData  (spRdData),
  .overflow  (overflow),
  .underflow (underflow)
);

// File: tb/rstk_top_tb.sv
module rstk_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushEn = 1'b0, popEn = 1'b0, spWrEn = 1'b0;
  logic [15:0] pushData = '0, spWrData = '0;
  logic [15:0] popData, spRdData;
  logic        overflow, underflow;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  rstk_top u_dut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn), .pushData(pushData),
    .spWrEn(spWrEn), .spWrData(spWrData), .popData(popData), .spRdData(spRdData),
    .overflow(overflow), .underflow(underflow)
  );

  typedef struct packed {
    logic        push;
    logic        pop;
    logic        pw;
    logic [15:0] d;
    logic [15:0] pd;
    logic [3:0]  ptr;
    logic        chkPop;
    logic [15:0] popv;
    logic        ovf;
    logic        und;
    logic [7:0]  req;
  } vec_t;

  function automatic vec_t mkv(logic pu, logic po, logic w, logic [15:0] d, logic [15:0] pd,
                               logic [3:0] p, logic cp, logic [15:0] pv, logic o, logic u,
                               logic [7:0] r);
    return '{push: pu, pop: po, pw: w, d: d, pd: pd, ptr: p, chkPop: cp, popv: pv,
             ovf: o, und: u, req: r};
  endfunction

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    mkv(1,0,0,16'hA001,16'h0,4'h0,0,16'h0,0,0,8'd4),   // R4: push at Fh wraps to 0
    mkv(1,0,0,16'hA002,16'h0,4'h1,0,16'h0,0,0,8'd2),   // R2
    mkv(1,0,0,16'hA003,16'h0,4'h2,0,16'h0,0,0,8'd2),   // R2
    mkv(0,1,0,16'h0,16'h0,4'h1,1,16'hA003,0,0,8'd3),   // R3
    mkv(0,1,0,16'h0,16'h0,4'h0,1,16'hA002,0,0,8'd3),   // R3
    mkv(1,1,0,16'hB004,16'h0,4'h1,1,16'hA002,0,0,8'd7),// R7: push only
    mkv(0,1,0,16'h0,16'h0,4'h0,1,16'hB004,0,0,8'd7),   // R7: value was stored
    mkv(0,1,0,16'h0,16'h0,4'hF,1,16'hA001,0,0,8'd4),   // R4: pop at 0 wraps to Fh
    mkv(0,1,0,16'h0,16'h0,4'hE,0,16'h0,0,1,8'd9),      // R9: empty pop
    mkv(0,0,0,16'h0,16'h0,4'hE,0,16'h0,0,0,8'd11),     // R11: idle hold, flag drops
    mkv(0,0,1,16'h0,16'hFFF5,4'h5,0,16'h0,0,0,8'd6),   // R6: upper bits ignored
    mkv(1,0,1,16'hC0C0,16'h0000,4'h0,0,16'h0,0,0,8'd6),// R6: write beats push
    mkv(0,0,1,16'h0,16'h0001,4'h1,0,16'h0,0,0,8'd6),   // R6
    mkv(0,1,0,16'h0,16'h0,4'h0,1,16'hB004,0,1,8'd10)   // R10/R6: no store, count still 0
  };

  task automatic chk(string what, int req, logic [15:0] act, logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic pu, logic po, logic w, logic [15:0] d, logic [15:0] pd);
    pushEn = pu; popEn = po; spWrEn = w; pushData = d; spWrData = pd;
    @(negedge clk);
    pushEn = 0; popEn = 0; spWrEn = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] keep;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("reset ptr", 1, spRdData, 16'h000F);
    chk("reset popData", 1, popData, 16'h0000);
    chk("reset flags", 1, {14'b0, overflow, underflow}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].push, VEC[i].pop, VEC[i].pw, VEC[i].d, VEC[i].pd);
      chk($sformatf("vec%0d ptr", i), int'(VEC[i].req), spRdData, {12'b0, VEC[i].ptr});
      chk($sformatf("vec%0d ovf", i), 8, {15'b0, overflow}, {15'b0, VEC[i].ovf});
      chk($sformatf("vec%0d und", i), 9, {15'b0, underflow}, {15'b0, VEC[i].und});
      if (VEC[i].chkPop)
        chk($sformatf("vec%0d popData", i), int'(VEC[i].req), popData, VEC[i].popv);
    end

    // R11: popData held across idle cycles
    keep = popData;
    drive(0, 0, 0, 16'h0, 16'h0);
    drive(1, 0, 0, 16'h1234, 16'h0);
    chk("popData held", 11, popData, keep);

    // R1: reset from a nonzero pointer
    rstN = 1'b0;
    @(negedge clk);
    chk("re-reset ptr", 1, spRdData, 16'h000F);
    chk("re-reset popData", 1, popData, 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: fill 16, then one more push overflows
    for (int i = 0; i < 16; i++) begin
      drive(1, 0, 0, 16'hD000 + 16'(i), 16'h0);
      chk("fill no ovf", 8, {15'b0, overflow}, 16'h0);
    end
    chk("fill ptr", 2, spRdData, 16'h000F);
    drive(1, 0, 0, 16'hE0E0, 16'h0);
    chk("ovf pulse", 8, {15'b0, overflow}, 16'h1);
    chk("ovf ptr moves", 8, spRdData, 16'h0000);
    drive(0, 0, 0, 16'h0, 16'h0);
    chk("ovf one cycle", 8, {15'b0, overflow}, 16'h0);

    // R10/R3: drain 16 without underflow, 17th underflows
    for (int k = 1; k <= 16; k++) begin
      drive(0, 1, 0, 16'h0, 16'h0);
      chk("drain und", 10, {15'b0, underflow}, 16'h0);
      if (k == 1) chk("drain data", 3, popData, 16'hE0E0);
      else        chk("drain data", 3, popData, 16'hD000 + 16'(17 - k));
    end
    drive(0, 1, 0, 16'h0, 16'h0);
    chk("drain underflow", 9, {15'b0, underflow}, 16'h1);
    chk("underflow ptr moves", 9, spRdData, 16'h000F);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule